// File: doc/BRIEF.md
# Data Memory Access Router

This block sits between a CPU's data port and three data targets: an on-chip RAM, a special-function-register (SFR) window, and external memory. For each request it picks exactly one target and drives that target's select, write enable and byte-lane enables. All three targets share one aligned address bus and one write-data bus. On a read, it takes the 16-bit word the chosen target returns in the same cycle and registers it. It then hands the result back one cycle later with a valid strobe.

The choice of target depends on the addressing mode and on whether the data-segment register is zero. In direct mode only the low 11 address bits count. The upper half of that 2 KB direct space is always the SFR window, whatever the segment register holds. In indirect mode, low addresses reach the on-chip RAM only while the segment register is zero. A forced-external mode always goes off chip. Word accesses are aligned down to an even address, and word data is little-endian.

The request side follows valid/ready rules. `req_ready` is held high, so a request is taken in every cycle in which `req_valid` is high, and the block applies no back-pressure. The response side has no ready: the consumer must accept `rsp_valid` in the cycle it appears.

Top module: `dmem_router`

## Requirements
- R1: In direct mode (`req_mode` = 2'b00), an effective address with bit 10 set (0x400 to 0x7FF) selects the SFR target, for any `ds_value`.
- R2: In direct mode with bit 10 clear, the on-chip RAM is selected when `ds_value` is zero and the address is below `IRAM_BYTES`; otherwise external memory is selected.
- R3: In indirect mode (`req_mode` = 2'b01), the on-chip RAM is selected when `ds_value` is zero and the full address is below `IRAM_BYTES`; otherwise external memory is selected. SFRs are never reached in this mode.
- R4: In forced-external mode (`req_mode` = 2'b10, and the spare code 2'b11), external memory is selected, even for addresses that overlap on-chip RAM or SFR space.
- R5: In direct mode, address bits above bit 10 are ignored, so `mem_addr` carries only bits 10:0 of the request.
- R6: A word access (`req_word` = 1) clears address bit 0 on `mem_addr` and enables both lanes (be = 2'b11).
- R7: A byte access enables lane 0 (be = 2'b01) at an even address and lane 1 (be = 2'b10) at an odd address. The write byte `req_wdata[7:0]` appears on both halves of `mem_wdata`.
- R8: Words are little-endian. The even byte travels on bits 7:0 and the odd byte on bits 15:8, both for writes and for the assembled `rsp_rdata`. A byte read returns the addressed byte zero-extended.
- R9: While `req_valid` is high exactly one target select is high, and while it is low none is. A write enable is high only on the selected target, and only for writes.
- R10: A read accepted in cycle n raises `rsp_valid` for exactly cycle n+1 with its data. A write produces no response.
- R11: `req_ready` is high in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_mode | input | 2 | 00 direct, 01 indirect, 10/11 forced external |
| ds_value | input | DS_W | Data-segment register value |
| mem_addr | output | ADDR_W | Aligned address, shared by all targets |
| mem_wdata | output | 16 | Lane-arranged write data, shared |
| iram_sel | output | 1 | On-chip RAM select |
| iram_we | output | 1 | On-chip RAM write enable |
| iram_be | output | 2 | On-chip RAM lane enables |
| iram_rdata | input | 16 | On-chip RAM word at `mem_addr` |
| sfr_sel | output | 1 | SFR select |
| sfr_we | output | 1 | SFR write enable |
| sfr_be | output | 2 | SFR lane enables |
| sfr_rdata | input | 16 | SFR word at `mem_addr` |
| xmem_sel | output | 1 | External memory select |
| xmem_we | output | 1 | External memory write enable |
| xmem_be | output | 2 | External memory lane enables |
| xmem_rdata | input | 16 | External memory word at `mem_addr` |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 16 | Assembled read data |

## Verification
A vector table is walked through every mode with both zero and nonzero segment values. It separates the SFR window from low direct space, on-chip from external for indirect addresses on both sides of the RAM size, and forced-external accesses that overlap on-chip space. Direct addresses with junk upper bits show that those bits are masked. Odd addresses on word accesses show that the address is aligned down and not rejected. Each table read is compared with target-specific memory patterns, so a wrong route or a swapped byte lane shows up in the data as well as in the selects. Directed writes of odd bytes and misaligned words, read back through other paths, confirm the byte order and that the other targets are left untouched.

// File: rtl/dmem_router_pkg.sv
package dmem_router_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_INDIRECT = 2'd1,
    MODE_EXTERNAL = 2'd2,
    MODE_EXT_ALT  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    TGT_IRAM = 2'd0,
    TGT_SFR  = 2'd1,
    TGT_XMEM = 2'd2
  } tgt_e;

  localparam int NUM_TGT = 3;
endpackage

// File: rtl/dmem_route_decode.sv
module dmem_route_decode
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DS_W       = 8,
  parameter int DIRECT_W   = 11,
  parameter int IRAM_BYTES = 2048
) (
  input  logic                req_valid,
  input  mode_e               mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                word,
  input  logic [DS_W-1:0]     ds,
  output tgt_e                tgt,
  output logic [ADDR_W-1:0]   eff_addr,
  output logic [NUM_TGT-1:0]  sel
);
  localparam int SFR_BIT = DIRECT_W - 1;

  logic [ADDR_W-1:0] base;
  logic              in_iram;

  always_comb begin
    base = addr;
    if (mode == MODE_DIRECT) begin
      base = '0;
      base[DIRECT_W-1:0] = addr[DIRECT_W-1:0];
    end
    eff_addr = word ? {base[ADDR_W-1:1], 1'b0} : base;
    in_iram  = (ds == '0) && ({1'b0, base} < (ADDR_W+1)'(IRAM_BYTES));
    case (mode)
      MODE_DIRECT:   tgt = base[SFR_BIT] ? TGT_SFR : (in_iram ? TGT_IRAM : TGT_XMEM);
      MODE_INDIRECT: tgt = in_iram ? TGT_IRAM : TGT_XMEM;
      default:       tgt = TGT_XMEM;
    endcase
    sel = '0;
    if (req_valid) sel[tgt] = 1'b1;
  end
endmodule

// File: rtl/dmem_lane_pack.sv
module dmem_lane_pack (
  input  logic        word,
  input  logic        addr0,
  input  logic [15:0] wdata_in,
  output logic [1:0]  be,
  output logic [15:0] wdata_out
);
  always_comb begin
    if (word) begin
      be        = 2'b11;
      wdata_out = wdata_in;
    end else begin
      be        = addr0 ? 2'b10 : 2'b01;
      wdata_out = {wdata_in[7:0], wdata_in[7:0]};
    end
  end
endmodule

// File: rtl/dmem_rsp_reg.sv
module dmem_rsp_reg
  import dmem_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  tgt_e        tgt,
  input  logic        word,
  input  logic        addr0,
  input  logic [15:0] iram_rdata,
  input  logic [15:0] sfr_rdata,
  input  logic [15:0] xmem_rdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata
);
  logic [15:0] raw;
  logic [15:0] shaped;

  always_comb begin
    case (tgt)
      TGT_IRAM: raw = iram_rdata;
      TGT_SFR:  raw = sfr_rdata;
      default:  raw = xmem_rdata;
    endcase
    shaped = word ? raw : {8'h00, (addr0 ? raw[15:8] : raw[7:0])};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= shaped;
    end
  end

  assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> rsp_valid);
  assert_rsp_only_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> !rsp_valid);
endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DS_W       = 8,
  parameter int DIRECT_W   = 11,
  parameter int IRAM_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mode,
  input  logic [DS_W-1:0]   ds_value,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              iram_sel,
  output logic              iram_we,
  output logic [1:0]        iram_be,
  input  logic [15:0]       iram_rdata,
  output logic              sfr_sel,
  output logic              sfr_we,
  output logic [1:0]        sfr_be,
  input  logic [15:0]       sfr_rdata,
  output logic              xmem_sel,
  output logic              xmem_we,
  output logic [1:0]        xmem_be,
  input  logic [15:0]       xmem_rdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata
);
  localparam int SFR_BIT = DIRECT_W - 1;

  tgt_e               tgt;
  logic [NUM_TGT-1:0] sel;
  logic [1:0]         be;
  logic               wr;

  assign req_ready = 1'b1;

  dmem_route_decode #(
    .ADDR_W(ADDR_W), .DS_W(DS_W), .DIRECT_W(DIRECT_W), .IRAM_BYTES(IRAM_BYTES)
  ) u_decode (
    .req_valid (req_valid),
    .mode      (mode_e'(req_mode)),
    .addr      (req_addr),
    .word      (req_word),
    .ds        (ds_value),
    .tgt       (tgt),
    .eff_addr  (mem_addr),
    .sel       (sel)
  );

  dmem_lane_pack u_lanes (
    .word      (req_word),
    .addr0     (req_addr[0]),
    .wdata_in  (req_wdata),
    .be        (be),
    .wdata_out (mem_wdata)
  );

  assign wr       = req_valid & req_write;
  assign iram_sel = sel[TGT_IRAM];
  assign sfr_sel  = sel[TGT_SFR];
  assign xmem_sel = sel[TGT_XMEM];
  assign iram_we  = iram_sel & wr;
  assign sfr_we   = sfr_sel & wr;
  assign xmem_we  = xmem_sel & wr;
  assign iram_be  = iram_sel ? be : 2'b00;
  assign sfr_be   = sfr_sel ? be : 2'b00;
  assign xmem_be  = xmem_sel ? be : 2'b00;

  dmem_rsp_reg u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (req_valid & ~req_write),
    .tgt        (tgt),
    .word       (req_word),
    .addr0      (req_addr[0]),
    .iram_rdata (iram_rdata),
    .sfr_rdata  (sfr_rdata),
    .xmem_rdata (xmem_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({iram_sel, sfr_sel, xmem_sel}));
  assert_idle_no_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ({iram_sel, sfr_sel, xmem_sel} == 3'b000));
  assert_sfr_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'b00 && req_addr[SFR_BIT]) |-> sfr_sel);
  assert_forced_external_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode[1]) |-> xmem_sel);
  assert_word_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word) |-> !mem_addr[0]);
  assert_indirect_no_sfr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'b01) |-> !sfr_sel);
endmodule

// File: tb/dmem_router_test.sv
`timescale 1ns/1ps
module dmem_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_word = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mode = '0;
  logic [7:0]  ds_value = '0;
  logic        req_ready;
  logic [15:0] mem_addr, mem_wdata, iram_rdata, sfr_rdata, xmem_rdata, rsp_rdata;
  logic        iram_sel, iram_we, sfr_sel, sfr_we, xmem_sel, xmem_we, rsp_valid;
  logic [1:0]  iram_be, sfr_be, xmem_be;
  int          n_run = 0, n_fail = 0;

  logic [7:0] iram [0:2047];
  logic [7:0] sfr  [0:1023];
  logic [7:0] xmem [0:4095];

  always #2.5 clk = ~clk;

  dmem_router uut (.*);

  assign iram_rdata = {iram[{mem_addr[10:1], 1'b1}], iram[{mem_addr[10:1], 1'b0}]};
  assign sfr_rdata  = {sfr[{mem_addr[9:1], 1'b1}],   sfr[{mem_addr[9:1], 1'b0}]};
  assign xmem_rdata = {xmem[{mem_addr[11:1], 1'b1}], xmem[{mem_addr[11:1], 1'b0}]};

  always @(posedge clk) begin
    if (iram_we && iram_be[0]) iram[{mem_addr[10:1], 1'b0}] <= mem_wdata[7:0];
    if (iram_we && iram_be[1]) iram[{mem_addr[10:1], 1'b1}] <= mem_wdata[15:8];
    if (sfr_we && sfr_be[0])   sfr[{mem_addr[9:1], 1'b0}]   <= mem_wdata[7:0];
    if (sfr_we && sfr_be[1])   sfr[{mem_addr[9:1], 1'b1}]   <= mem_wdata[15:8];
    if (xmem_we && xmem_be[0]) xmem[{mem_addr[11:1], 1'b0}] <= mem_wdata[7:0];
    if (xmem_we && xmem_be[1]) xmem[{mem_addr[11:1], 1'b1}] <= mem_wdata[15:8];
  end

  // fields: mode, ds, addr, word, target(0 iram,1 sfr,2 xmem), expected addr, expected be
  localparam int NV = 13;
  localparam logic [46:0] VEC [NV] = '{
    {2'd0, 8'h00, 16'h0123, 1'b0, 2'd0, 16'h0123, 2'b10},  // R2 low direct, ds zero
    {2'd0, 8'h00, 16'h0400, 1'b1, 2'd1, 16'h0400, 2'b11},  // R1
    {2'd0, 8'h05, 16'h0455, 1'b1, 2'd1, 16'h0454, 2'b11},  // R1 ds nonzero, R6 misaligned
    {2'd0, 8'h05, 16'h0010, 1'b0, 2'd2, 16'h0010, 2'b01},  // R2 ds nonzero
    {2'd0, 8'h00, 16'hF7FF, 1'b0, 2'd1, 16'h07FF, 2'b10},  // R5 masked upper bits
    {2'd0, 8'h00, 16'h3BFF, 1'b1, 2'd0, 16'h03FE, 2'b11},  // R5 and R6
    {2'd1, 8'h00, 16'h07FF, 1'b0, 2'd0, 16'h07FF, 2'b10},  // R3 last on-chip byte
    {2'd1, 8'h00, 16'h0800, 1'b0, 2'd2, 16'h0800, 2'b01},  // R3 beyond RAM size
    {2'd1, 8'h01, 16'h0100, 1'b1, 2'd2, 16'h0100, 2'b11},  // R3 ds nonzero
    {2'd1, 8'h00, 16'h0401, 1'b1, 2'd0, 16'h0400, 2'b11},  // R3 no SFR window
    {2'd2, 8'h00, 16'h0020, 1'b1, 2'd2, 16'h0020, 2'b11},  // R4
    {2'd3, 8'h00, 16'h0456, 1'b0, 2'd2, 16'h0456, 2'b01},  // R4 spare code
    {2'd2, 8'h00, 16'h0400, 1'b0, 2'd2, 16'h0400, 2'b01}   // R4 overlaps SFR
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] peek(input int t, input logic [15:0] a);
    if (t == 0) return iram[a[10:0]];
    if (t == 1) return sfr[a[9:0]];
    return xmem[a[11:0]];
  endfunction

  task automatic drive(input logic [1:0] m, input logic [7:0] ds, input logic [15:0] a,
                       input logic w, input logic wr, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; ds_value = ds; req_addr = a;
    req_word = w; req_write = wr; req_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // read and return response sampled one cycle later
  task automatic rd(input logic [1:0] m, input logic [7:0] ds, input logic [15:0] a,
                    input logic w, output logic [15:0] q);
    drive(m, ds, a, w, 1'b0, 16'h0);
    idle();
    chk("R10 read strobe", {31'd0, rsp_valid}, 32'd1);
    q = rsp_rdata;
  endtask

  initial begin
    logic [15:0] q;
    for (int i = 0; i < 2048; i++) iram[i] = 8'(i) ^ 8'h11;
    for (int i = 0; i < 1024; i++) sfr[i]  = 8'(i) ^ 8'h22;
    for (int i = 0; i < 4096; i++) xmem[i] = 8'(i) ^ 8'h33;
    #1;
    chk("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R9 no select in reset", {29'd0, iram_sel, sfr_sel, xmem_sel}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [1:0] exp_be; logic [15:0] exp_a; int t; logic [15:0] exp_d;
      t = int'(VEC[v][19:18]); exp_a = VEC[v][17:2]; exp_be = VEC[v][1:0];
      drive(VEC[v][46:45], VEC[v][44:37], VEC[v][36:21], VEC[v][20], 1'b0, 16'h0);
      #1;
      chk("R1-route R2 R3 R4 target", {29'd0, xmem_sel, sfr_sel, iram_sel}, 32'(3'b001 << t));
      chk("R5 R6 address", {16'd0, mem_addr}, {16'd0, exp_a});
      chk("R6 R7 lanes", {30'd0, iram_be | sfr_be | xmem_be}, {30'd0, exp_be});
      chk("R9 no write enable on read", {29'd0, iram_we, sfr_we, xmem_we}, 32'd0);
      chk("R11 ready", {31'd0, req_ready}, 32'd1);
      exp_d = VEC[v][20] ? {peek(t, exp_a | 16'h1), peek(t, exp_a)} : {8'h00, peek(t, exp_a)};
      idle();
      chk("R10 response strobe", {31'd0, rsp_valid}, 32'd1);
      chk("R8 response data", {16'd0, rsp_rdata}, {16'd0, exp_d});
    end
    @(negedge clk);
    chk("R10 single-cycle strobe", {31'd0, rsp_valid}, 32'd0);
    chk("R9 idle no select", {29'd0, iram_sel, sfr_sel, xmem_sel}, 32'd0);

    // misaligned word write to on-chip RAM, read back as bytes
    drive(2'd1, 8'h00, 16'h0203, 1'b1, 1'b1, 16'hBEEF);
    #1;
    chk("R9 write enable on target", {29'd0, xmem_we, sfr_we, iram_we}, 32'd1);
    chk("R8 write data lanes", {16'd0, mem_wdata}, 32'hBEEF);
    idle();
    chk("R10 no response to write", {31'd0, rsp_valid}, 32'd0);
    rd(2'd1, 8'h00, 16'h0202, 1'b0, q);
    chk("R8 low byte at even address", {16'd0, q}, 32'hEF);
    rd(2'd1, 8'h00, 16'h0203, 1'b0, q);
    chk("R8 high byte at odd address", {16'd0, q}, 32'hBE);

    // odd byte write to SFR with nonzero segment
    drive(2'd0, 8'h7F, 16'h0401, 1'b0, 1'b1, 16'h995A);
    #1;
    chk("R7 byte replicated", {16'd0, mem_wdata}, 32'h5A5A);
    chk("R1 SFR with ds nonzero", {31'd0, sfr_we}, 32'd1);
    idle();
    rd(2'd0, 8'h7F, 16'h0400, 1'b1, q);
    chk("R7 only odd lane written", {16'd0, q}, {16'd0, 8'h5A, 8'h22});

    // forced external write over on-chip range leaves on-chip RAM unchanged
    drive(2'd2, 8'h00, 16'h0011, 1'b1, 1'b1, 16'h1234);
    idle();
    rd(2'd2, 8'h00, 16'h0010, 1'b1, q);
    chk("R4 external word", {16'd0, q}, 32'h1234);
    rd(2'd1, 8'h00, 16'h0010, 1'b1, q);
    chk("R4 on-chip untouched", {16'd0, q}, {16'd0, 8'h11 ^ 8'h11, 8'h10 ^ 8'h11});
    @(negedge clk);
    chk("R10 back to idle", {31'd0, rsp_valid}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule